// File: doc/BRIEF.md
# Adaptive Line-Comb Luma/Chroma Separator

This block splits a stream of 8-bit composite video samples, taken at four times the colour subcarrier rate, into a luma stream and a chroma stream. It holds three vertically adjacent taps of the picture in circular line memories. For each sample it measures how closely the centre line matches the lines above and below. When both neighbours agree, it uses a vertical comb. When they do not, it falls back to a horizontal bandpass around the subcarrier. Chroma leaves the block in offset-binary form, with 128 standing for zero.

A two-bit mode input forces bandpass-only separation or raw pass-through. A two-bit standard input sets the vertical tap spacing: one line for the 60-field standard, two lines for the three 50-field/PAL-family codes. A valid strobe qualifies each input sample, and only qualified samples advance the line memories and the horizontal neighbours. Every accepted sample yields exactly one output pair, a fixed number of clocks later.

Top module: `yc_comb_split`

## Requirements
- R1: A synchronous active-low reset drives `vld_o`, `luma_o` and `chroma_o` to 0 and fills every line memory and window register with the blanking value `BLANK`. Results taken just after reset therefore treat all earlier history as `BLANK`.
- R2: Each cycle with `vld_i`=1 produces exactly one cycle with `vld_o`=1, `LATENCY` (default 20) clocks later. Outputs come out in input order, whatever the gaps between inputs.
- R3: The tap spacing S is `LINE_LEN` samples when `std_i`=00 and 2·`LINE_LEN` for `std_i`=01, 10 and 11. The result emitted for accepted input number n concerns centre sample m = x[n−S], with top t = x[n−2S] and bottom b = x[n].
- R4: With `mode_i`=10 (bandpass only), c = floor((2m − x[n−S+2] − x[n−S−2]) / 4) is taken on the centre line. `chroma_o` = c + 128 and `luma_o` = m − c, clamped to 0..255.
- R5: With `mode_i`=00 (adaptive), the comb value c = floor((2m − t − b) / 4) replaces the bandpass value when |m−t| < `thr_i` and |m−b| < `thr_i`. Output forms follow R4. Code 01 behaves exactly like 00.
- R6: With `mode_i`=11 (pass-through), `luma_o` = `chroma_o` = m, unmodified.
- R7: `mode_i` and `thr_i` are taken in the same cycle as accepted input n and apply to the result for input n alone, so the mode may change on every sample.
- R8: Cycles with `vld_i`=0 change neither the line memories nor the horizontal neighbours, so inserting gaps leaves every result unchanged.
- R9: In every mode except pass-through, `luma_o` + `chroma_o` − 128 equals m exactly.
- R10: The threshold comparison is strict: a neighbour difference equal to `thr_i` selects bandpass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vld_i | input | 1 | Qualifies `smp_i` in this cycle |
| smp_i | input | 8 | Composite sample, unsigned |
| mode_i | input | 2 | Separation mode: 00/01 adaptive, 10 bandpass, 11 pass-through |
| std_i | input | 2 | Colour standard: 00 one-line spacing, others two-line spacing |
| thr_i | input | 8 | Correlation threshold for the comb decision |
| vld_o | output | 1 | Qualifies the output pair |
| luma_o | output | 8 | Luma, unsigned |
| chroma_o | output | 8 | Chroma, offset binary (128 = zero) |

## Verification
In the same clock, the block can accept a new sample at the input, emit the result of a sample taken twenty clocks earlier, and switch mode for the incoming sample. The bench provokes this with back-to-back valid streams whose mode code rotates on every sample, mixed with irregular idle gaps. A scoreboard model compares each emitted pair against a history of accepted samples, using the mode and threshold recorded with that very sample and the exact emission cycle. Line patterns that alternate by a fixed step pin the comb decision to the threshold boundary on both sides.

// File: rtl/yc_comb_split_pkg.sv
// Shared types and arithmetic helpers for the luma/chroma separator.
// Assumes 8-bit unsigned samples; intermediate sums fit in 11 signed bits.
package yc_comb_split_pkg;

    typedef logic [7:0] pix_t;

    typedef enum logic [1:0] {
        SEP_ADAPT     = 2'b00,
        SEP_ADAPT_ALT = 2'b01,
        SEP_BAND      = 2'b10,
        SEP_PASS      = 2'b11
    } sep_mode_e;

    // Absolute difference of two unsigned samples.
    function automatic pix_t abs_diff(input pix_t a, input pix_t b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

    // floor((2c - p - q) / 4); the result always fits in 8 signed bits.
    function automatic logic signed [7:0] quarter_hp(input pix_t c, input pix_t p, input pix_t q);
        logic signed [10:0] s;
        logic signed [10:0] sh;
        s  = $signed({2'b00, c, 1'b0}) - $signed({3'b000, p}) - $signed({3'b000, q});
        sh = s >>> 2;
        return sh[7:0];
    endfunction

    // Clamp a signed value into the unsigned 8-bit range.
    function automatic pix_t clamp_u8(input logic signed [10:0] v);
        if (v < 0)
            return 8'd0;
        else if (v > 11'sd255)
            return 8'd255;
        else
            return v[7:0];
    endfunction

endpackage

// File: rtl/yc_line_delay.sv
// Circular sample delay with a runtime-selected distance.
// One write pointer; the tap is read combinationally before the write, so
// tap_o is the sample written dist_i accepted samples ago.
// Assumes 1 <= dist_i <= DEPTH. Reset fills storage with BLANK.
module yc_line_delay #(
    parameter int          DEPTH = 1820,
    parameter logic [7:0]  BLANK = 8'h10,
    localparam int         PW    = $clog2(DEPTH),
    localparam int         DW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  logic [DW-1:0] dist_i,
    input  logic [7:0]    d_i,
    output logic [7:0]    tap_o
);
    localparam int CW = $clog2(2 * DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wp;
    logic [CW-1:0] raw;
    logic [PW-1:0] rd;

    // Read address: write pointer minus distance, modulo DEPTH.
    always_comb begin
        raw = CW'(wp) + CW'(DEPTH) - CW'(dist_i);
        rd  = (raw >= CW'(DEPTH)) ? PW'(raw - CW'(DEPTH)) : PW'(raw);
    end

    assign tap_o = mem[rd];

    // Storage write and pointer advance on accepted samples only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK;
            wp <= '0;
        end else if (adv_i) begin
            mem[wp] <= d_i;
            wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        end
    end

    // R8: an idle cycle never moves the write pointer.
    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(wp));

endmodule

// File: rtl/yc_tap_window.sv
// Builds the 3-line by 5-sample neighbourhood used by the separator.
// Centre line is delayed S-2 then shifted through 5 registers so that the
// centre register holds x[n-S]; top line is the centre delayed a further S.
// Assumes LINE_LEN >= 3. Everything advances only on vld_i.
module yc_tap_window
    import yc_comb_split_pkg::*;
#(
    parameter int         LINE_LEN = 910,
    parameter logic [7:0] BLANK    = 8'h10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    input  logic wide_i,
    input  pix_t smp_i,
    output logic v_o,
    output pix_t ctr_o,
    output pix_t left_o,
    output pix_t right_o,
    output pix_t top_o,
    output pix_t bot_o
);
    localparam int DEPTH = 2 * LINE_LEN;
    localparam int DW    = $clog2(DEPTH + 1);
    localparam int HT    = 5;

    logic [DW-1:0] dist_mid, dist_top;
    pix_t          mid_tap, top_tap;
    pix_t          hwin [HT];
    pix_t          top_q, bot_q;

    // Tap distances for one-line or two-line spacing.
    always_comb begin
        dist_top = wide_i ? DW'(2 * LINE_LEN) : DW'(LINE_LEN);
        dist_mid = dist_top - DW'(2);
    end

    yc_line_delay #(.DEPTH(DEPTH), .BLANK(BLANK)) u_mid (
        .clk(clk), .rst_n(rst_n), .adv_i(vld_i),
        .dist_i(dist_mid), .d_i(smp_i), .tap_o(mid_tap));

    yc_line_delay #(.DEPTH(DEPTH), .BLANK(BLANK)) u_top (
        .clk(clk), .rst_n(rst_n), .adv_i(vld_i),
        .dist_i(dist_top), .d_i(hwin[1]), .tap_o(top_tap));

    // Horizontal shift of the centre line; entry 0 is the newest sample.
    generate
        for (genvar k = 0; k < HT; k++) begin : g_h
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hwin[k] <= BLANK;
                else if (vld_i)
                    hwin[k] <= (k == 0) ? mid_tap : hwin[(k == 0) ? 0 : k - 1];
            end
        end
    endgenerate

    // Outer-line capture and window-valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= BLANK;
            bot_q <= BLANK;
            v_o   <= 1'b0;
        end else begin
            v_o <= vld_i;
            if (vld_i) begin
                top_q <= top_tap;
                bot_q <= smp_i;
            end
        end
    end

    assign ctr_o   = hwin[2];
    assign left_o  = hwin[0];
    assign right_o = hwin[4];
    assign top_o   = top_q;
    assign bot_o   = bot_q;

endmodule

// File: rtl/yc_sep_core.sv
// Per-sample separation: correlation decision, comb or bandpass chroma,
// luma as the complement, and mode muxing. One register stage.
// Assumes the window inputs are stable while v_i is high.
module yc_sep_core
    import yc_comb_split_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      v_i,
    input  sep_mode_e mode_i,
    input  pix_t      thr_i,
    input  pix_t      ctr_i,
    input  pix_t      left_i,
    input  pix_t      right_i,
    input  pix_t      top_i,
    input  pix_t      bot_i,
    output logic      v_o,
    output pix_t      y_o,
    output pix_t      c_o
);
    logic               near_top, near_bot, use_comb;
    logic signed [7:0]  c_band, c_comb, c_sel;
    pix_t               y_nx, c_nx;

    // Correlation decision and chroma/luma arithmetic.
    always_comb begin
        near_top = abs_diff(ctr_i, top_i) < thr_i;
        near_bot = abs_diff(ctr_i, bot_i) < thr_i;
        use_comb = !mode_i[1] && near_top && near_bot;
        c_band   = quarter_hp(ctr_i, left_i, right_i);
        c_comb   = quarter_hp(ctr_i, top_i, bot_i);
        c_sel    = use_comb ? c_comb : c_band;
        if (mode_i == SEP_PASS) begin
            y_nx = ctr_i;
            c_nx = ctr_i;
        end else begin
            y_nx = clamp_u8($signed({3'b000, ctr_i}) - $signed({{3{c_sel[7]}}, c_sel}));
            c_nx = pix_t'(c_sel) ^ 8'h80;
        end
    end

    // Result register, loaded on qualified window cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o <= 1'b0;
            y_o <= '0;
            c_o <= '0;
        end else begin
            v_o <= v_i;
            if (v_i) begin
                y_o <= y_nx;
                c_o <= c_nx;
            end
        end
    end

    // R9: luma and chroma recombine to the centre sample outside pass-through.
    a_r9_complement: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(v_i) && $past(mode_i) != SEP_PASS)
        |-> (10'(y_o) + 10'(c_o) == 10'($past(ctr_i)) + 10'd128));

    // R6: pass-through copies the centre sample to both outputs.
    a_r6_pass_copy: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(v_i) && $past(mode_i) == SEP_PASS)
        |-> (y_o == $past(ctr_i) && c_o == $past(ctr_i)));

endmodule

// File: rtl/yc_fix_pipe.sv
// Fixed-length register pipeline that pads the path to its target latency.
// STAGES = 0 yields a plain wire. Reset clears all stages.
module yc_fix_pipe #(
    parameter int W      = 17,
    parameter int STAGES = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        if (STAGES == 0) begin : g_wire
            assign q_o = d_i;
        end else begin : g_regs
            logic [W-1:0] st [STAGES];
            // Shift every stage each clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) st[i] <= '0;
                end else begin
                    st[0] <= d_i;
                    for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
                end
            end
            assign q_o = st[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/yc_comb_split.sv
// Top: adaptive line-comb luma/chroma separator.
// Window (1 clock) + separation (1 clock) + padding (LATENCY-2 clocks).
// Assumes std_i is held constant between resets; LATENCY >= 2.
module yc_comb_split
    import yc_comb_split_pkg::*;
#(
    parameter int         LINE_LEN = 910,
    parameter int         LATENCY  = 20,
    parameter logic [7:0] BLANK    = 8'h10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vld_i,
    input  logic [7:0] smp_i,
    input  logic [1:0] mode_i,
    input  logic [1:0] std_i,
    input  logic [7:0] thr_i,
    output logic       vld_o,
    output logic [7:0] luma_o,
    output logic [7:0] chroma_o
);
    localparam int PAD = LATENCY - 2;
    localparam int PW  = 1 + 2 * 8;

    logic      v1, v2;
    pix_t      ctr, lft, rgt, top, bot;
    sep_mode_e mode_q;
    pix_t      thr_q;
    pix_t      y2, c2;
    logic [PW-1:0] pipe_q;

    yc_tap_window #(.LINE_LEN(LINE_LEN), .BLANK(BLANK)) u_win (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .wide_i(std_i != 2'b00),
        .smp_i(smp_i), .v_o(v1), .ctr_o(ctr), .left_o(lft), .right_o(rgt),
        .top_o(top), .bot_o(bot));

    // Capture mode and threshold with the sample they belong to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SEP_ADAPT;
            thr_q  <= '0;
        end else if (vld_i) begin
            mode_q <= sep_mode_e'(mode_i);
            thr_q  <= thr_i;
        end
    end

    yc_sep_core u_core (
        .clk(clk), .rst_n(rst_n), .v_i(v1), .mode_i(mode_q), .thr_i(thr_q),
        .ctr_i(ctr), .left_i(lft), .right_i(rgt), .top_i(top), .bot_i(bot),
        .v_o(v2), .y_o(y2), .c_o(c2));

    yc_fix_pipe #(.W(PW), .STAGES(PAD)) u_pad (
        .clk(clk), .rst_n(rst_n), .d_i({v2, y2, c2}), .q_o(pipe_q));

    assign vld_o    = pipe_q[PW-1];
    assign luma_o   = pipe_q[15:8];
    assign chroma_o = pipe_q[7:0];

    // R2: the separation stage is qualified exactly two clocks after input.
    a_r2_stage_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (v2 == $past(vld_i, 2)));

endmodule

// File: tb/sim_yc_comb_split.sv
// Scoreboard bench: driver computes expected pairs from a sample history,
// monitor pops and compares them as results appear.
module sim_yc_comb_split;

    localparam int         LL    = 16;
    localparam int         LAT   = 20;
    localparam logic [7:0] BLANK = 8'h10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vld_i = 1'b0;
    logic [7:0] smp_i = '0;
    logic [1:0] mode_i = '0;
    logic [1:0] std_i = '0;
    logic [7:0] thr_i = '0;
    logic       vld_o;
    logic [7:0] luma_o, chroma_o;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    int hist[$];
    int q_y[$], q_c[$], q_cyc[$], q_m[$];
    string q_tag[$];
    int lfsr = 32'h1ace;

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    yc_comb_split #(.LINE_LEN(LL), .LATENCY(LAT), .BLANK(BLANK)) u0 (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .smp_i(smp_i),
        .mode_i(mode_i), .std_i(std_i), .thr_i(thr_i),
        .vld_o(vld_o), .luma_o(luma_o), .chroma_o(chroma_o));

    function automatic int rnd();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h8000_0057 : 0);
        return lfsr & 255;
    endfunction

    function automatic int hget(int k);
        return (k < 0) ? int'(BLANK) : hist[k];
    endfunction

    function automatic int fl4(int v);
        return (v >= 0) ? v / 4 : -((-v + 3) / 4);
    endfunction

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: present one sample for one cycle and record its expected pair.
    task automatic send(int x, int md, int th, string tag);
        int n, s, m, t, b, l, r, c, y, co;
        hist.push_back(x);
        n = hist.size() - 1;
        s = (std_i == 2'b00) ? LL : 2 * LL;
        m = hget(n - s); t = hget(n - 2 * s); b = hget(n);
        l = hget(n - s + 2); r = hget(n - s - 2);
        if (md == 3) begin
            y = m; co = m;
        end else begin
            if (md[1] == 0 && iabs(m - t) < th && iabs(m - b) < th)
                c = fl4(2 * m - t - b);
            else
                c = fl4(2 * m - l - r);
            y = m - c;
            if (y < 0) y = 0;
            if (y > 255) y = 255;
            co = c + 128;
        end
        q_y.push_back(y); q_c.push_back(co); q_cyc.push_back(cyc);
        q_m.push_back(md == 3 ? -1 : m); q_tag.push_back(tag);
        vld_i = 1'b1; smp_i = 8'(x); mode_i = 2'(md); thr_i = 8'(th);
        @(negedge clk);
        vld_i = 1'b0;
        smp_i = 8'(rnd());
        mode_i = 2'(rnd());
    endtask

    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic drain();
        int t = 0;
        while (q_y.size() != 0 && t < 200) begin @(negedge clk); t++; end
        idle(3);
    endtask

    // Reset with a chosen standard; R1 state checked afterwards.
    task automatic do_reset(int s);
        rst_n = 1'b0; std_i = 2'(s); vld_i = 1'b0;
        idle(3);
        rst_n = 1'b1;
        hist.delete();
        idle(1);
        check(vld_o == 1'b0, "R1 vld_o after reset", vld_o, 0);
        check(luma_o == 8'd0 && chroma_o == 8'd0, "R1 outputs after reset",
              {luma_o, chroma_o}, 0);
    endtask

    // Monitor: compare each emitted pair against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && vld_o) begin
            if (q_y.size() == 0) begin
                check(1'b0, "R2 unexpected vld_o", 1, 0);
            end else begin
                int ey, ec, ecy, em;
                string tg;
                ey = q_y.pop_front(); ec = q_c.pop_front();
                ecy = q_cyc.pop_front(); em = q_m.pop_front();
                tg = q_tag.pop_front();
                check(cyc - ecy == LAT, "R2 latency", cyc - ecy, LAT);
                check(int'(luma_o) == ey, {tg, " luma"}, luma_o, ey);
                check(int'(chroma_o) == ec, {tg, " chroma"}, chroma_o, ec);
                if (em >= 0)
                    check(int'(luma_o) + int'(chroma_o) - 128 == em,
                          "R9 recombine", int'(luma_o) + int'(chroma_o) - 128, em);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", q_y.size());
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // Bandpass mode, one-line spacing, random data with gaps (R1 R4 R8).
        do_reset(0);
        for (int i = 0; i < 3 * LL; i++) begin
            send(rnd(), 2, 0, (i < LL) ? "R1 R4" : "R4 R8");
            if (i % 5 == 3) idle(1 + (i % 3));
        end
        drain();

        // Threshold boundary: lines alternate by 6 (R10 then R5).
        do_reset(0);
        for (int i = 0; i < 4 * LL; i++)
            send(((i % LL) * 13 + 40) % 200 + ((i / LL) % 2) * 6, 0, 6, "R10");
        for (int i = 0; i < 4 * LL; i++)
            send(((i % LL) * 13 + 40) % 200 + ((i / LL) % 2) * 6, 0, 7, "R5");
        drain();

        // Two-line spacing with per-sample mode rotation (R3 R7).
        do_reset(1);
        for (int i = 0; i < 6 * LL; i++) begin
            send(((i % LL) * 29) % 180 + (rnd() & 7), i % 4, 40, "R3 R7");
            if (i % 7 == 6) idle(2);
        end
        drain();

        // Pass-through on standard 10 (R6).
        do_reset(2);
        for (int i = 0; i < 5 * LL; i++) send(rnd(), 3, 0, "R6");
        drain();

        // Adaptive on standard 11 with correlated lines (R3 R5).
        do_reset(3);
        for (int i = 0; i < 6 * LL; i++)
            send(((i % LL) * 37) % 220 + (rnd() & 3), (i % 3 == 0) ? 1 : 0, 30, "R3 R5");
        drain();

        check(q_y.size() == 0, "R2 all results emitted", q_y.size(), 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule